// File: doc/BRIEF.md
# Memory Cycle Timing Sequencer

This block produces the two non-overlapping processor clock phases for a DRAM memory controller and sets the length of every bus cycle. It runs from a fast base clock with a 4 ns tick. The processor announces the next cycle with two signals, `nmreq` and `seq`. From that announcement the block picks a long phase 1 for a non-sequential cycle, a short phase 1 for a sequential cycle, and one memory-clock period for an internal cycle. An internal cycle that is followed by a sequential fetch is fused into a single non-sequential-length cycle, which saves a whole cycle.

The `legacy` input selects between corrected timing and an exact reproduction of an older controller revision. That revision had three timing faults. It refuses to fuse when the fetch address has both address bits 2 and 3 set. It runs an internal cycle at double length when that cycle directly follows a real non-sequential cycle. It turns every internal cycle after the first one in a run into a non-sequential cycle. A replacement part can therefore match the instruction timings of either revision.

Sampling rules: an announcement is sampled on the clock edge that ends a cycle, which is the edge where `cycle_done` is high. During an internal cycle, the inputs are sampled again on the last tick of the short phase 1 to decide whether to fuse. `legacy` must stay static while out of reset.

Top module: `mcyc_seq`

## Requirements
- R1: While `rst_n` is low, `phase1`, `phase2` and `cycle_done` are all low. The first cycle starts one tick after `rst_n` is released.
- R2: `phase1` and `phase2` are never high together. Each cycle is one phase-1 run followed by one phase-2 run of 14 ticks. `cycle_done` is high only in the last tick of phase 2, and phase 1 of the next cycle follows at once.
- R3: The announcement `nmreq`=0, `seq`=0 gives a non-sequential cycle: tag 2'b00, phase 1 of 44 ticks, phase 2 of 14 ticks.
- R4: The announcement `nmreq`=0, `seq`=1 gives a sequential cycle: tag 2'b01, phase 1 of 14 ticks, phase 2 of 14 ticks.
- R5: The announcement `nmreq`=1, with `seq` ignored, gives an internal cycle: tag 2'b10, phase 1 of 14 ticks and phase 2 of 14 ticks, which is one memory clock.
- R6: An internal cycle whose next announcement is sequential is fused. The tag becomes 2'b11 by the end of the cycle, phase 1 lasts 44 ticks, and the sequential announcement is consumed. The cycle after the fused one takes the following announcement.
- R7: In corrected mode (`legacy`=0), address bits 2 and 3 have no effect on fusing. Internal cycles after a non-sequential cycle keep 14 ticks. Internal cycles in a run all stay internal, and the last one may still fuse.
- R8: In legacy mode, no fusion takes place when the sequential announcement has `a2`=1 and `a3`=1. The internal and sequential cycles then run separately. A single set bit does not block fusion.
- R9: In legacy mode, an internal cycle right after a true non-sequential cycle has a phase 1 of 42 ticks, so the whole cycle is two memory clocks.
- R10: In legacy mode, a fused cycle does not count as non-sequential. An internal cycle after a fused cycle runs at 14 ticks.
- R11: In legacy mode, every internal announcement that follows an internal announcement runs as a non-sequential cycle: tag 2'b00, 44 ticks, and it never fuses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, 4 ns tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmreq | input | 1 | Memory request, low = memory cycle |
| seq | input | 1 | Sequential indicator for the announced cycle |
| a2 | input | 1 | Address bit 2 of the announced fetch |
| a3 | input | 1 | Address bit 3 of the announced fetch |
| legacy | input | 1 | 1 = reproduce the older revision's timing faults |
| phase1 | output | 1 | Processor clock phase 1 |
| phase2 | output | 1 | Processor clock phase 2 |
| cyc_tag | output | 2 | Current cycle: 00 N, 01 S, 10 I, 11 fused |
| cycle_done | output | 1 | High in the final tick of each cycle |

## Verification
The bench runs scripted announcement sequences in both modes and measures phase 1 and phase 2 ticks, together with the tag, for every cycle. It covers these corner cases, each of which exposes a specific fault:
- An internal cycle fusing with a fetch whose address has both bits set. A design that applied the block in the wrong mode would show two separate cycles where one was due, or one where two were due.
- An internal cycle after a real non-sequential cycle, compared with one after a fused cycle. A design that treated the fused cycle as non-sequential would add 28 ticks.
- Runs of internal cycles in legacy mode. A design that forgot the conversion, or allowed a converted cycle to fuse, would show 14-tick cycles or a consumed fetch.
- A slowed internal cycle that still fuses.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [1:0] {
    TAG_N = 2'b00,
    TAG_S = 2'b01,
    TAG_I = 2'b10,
    TAG_M = 2'b11
  } cyc_tag_t;

  typedef enum logic [1:0] {
    REQ_N = 2'b00,
    REQ_S = 2'b01,
    REQ_I = 2'b10
  } req_t;

  typedef enum logic [1:0] {
    ST_BOOT = 2'b00,
    ST_P1   = 2'b01,
    ST_P2   = 2'b10
  } phase_st_t;

  function automatic req_t decode_req(input logic nmreq, input logic seq);
    if (nmreq)
      return REQ_I;
    else if (seq)
      return REQ_S;
    else
      return REQ_N;
  endfunction

endpackage

// File: rtl/mcyc_classify.sv
module mcyc_classify
  import mcyc_pkg::*;
#(
  parameter int CW       = 6,
  parameter int P1_LONG  = 44,
  parameter int P1_SHORT = 14,
  parameter int P1_SLOW  = 42
) (
  input  req_t         req,
  input  logic         legacy,
  input  cyc_tag_t     last_tag,
  input  logic         last_was_i,
  output cyc_tag_t     start_tag,
  output logic [CW-1:0] start_len
);

  always_comb begin
    start_tag = TAG_N;
    start_len = CW'(P1_LONG);
    unique case (req)
      REQ_S: begin
        start_tag = TAG_S;
        start_len = CW'(P1_SHORT);
      end
      REQ_I: begin
        if (legacy && last_was_i) begin
          // run of internal cycles: later members run as non-sequential
          start_tag = TAG_N;
          start_len = CW'(P1_LONG);
        end else if (legacy && last_tag == TAG_N) begin
          start_tag = TAG_I;
          start_len = CW'(P1_SLOW);
        end else begin
          start_tag = TAG_I;
          start_len = CW'(P1_SHORT);
        end
      end
      default: begin
        start_tag = TAG_N;
        start_len = CW'(P1_LONG);
      end
    endcase
  end

endmodule

// File: rtl/mcyc_merge.sv
module mcyc_merge
  import mcyc_pkg::*;
(
  input  logic     at_check,
  input  cyc_tag_t cur_tag,
  input  req_t     req,
  input  logic     a2,
  input  logic     a3,
  input  logic     legacy,
  output logic     merge_now
);

  logic addr_block;

  assign addr_block = legacy && a2 && a3;
  assign merge_now  = at_check && (cur_tag == TAG_I) && (req == REQ_S) && !addr_block;

endmodule

// File: rtl/mcyc_phase_gen.sv
module mcyc_phase_gen
  import mcyc_pkg::*;
#(
  parameter int CW       = 6,
  parameter int P1_LONG  = 44,
  parameter int P1_SHORT = 14,
  parameter int P2_LEN   = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_tag_t      start_tag,
  input  logic [CW-1:0] start_len,
  input  logic          merge_now,
  output logic          phase1,
  output logic          phase2,
  output logic          done,
  output logic          booting,
  output logic          at_check,
  output cyc_tag_t      tag
);

  phase_st_t     st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] p1_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_BOOT;
      cnt    <= '0;
      p1_len <= CW'(P1_SHORT);
      tag    <= TAG_N;
    end else begin
      unique case (st)
        ST_BOOT: begin
          st     <= ST_P1;
          cnt    <= '0;
          p1_len <= start_len;
          tag    <= start_tag;
        end
        ST_P1: begin
          if (merge_now) begin
            p1_len <= CW'(P1_LONG);
            tag    <= TAG_M;
            cnt    <= CW'(cnt + CW'(1));
          end else if (cnt == p1_len - CW'(1)) begin
            st  <= ST_P2;
            cnt <= '0;
          end else begin
            cnt <= CW'(cnt + CW'(1));
          end
        end
        ST_P2: begin
          if (cnt == CW'(P2_LEN - 1)) begin
            st     <= ST_P1;
            cnt    <= '0;
            p1_len <= start_len;
            tag    <= start_tag;
          end else begin
            cnt <= CW'(cnt + CW'(1));
          end
        end
        default: st <= ST_BOOT;
      endcase
    end
  end

  assign phase1   = (st == ST_P1);
  assign phase2   = (st == ST_P2);
  assign done     = (st == ST_P2) && (cnt == CW'(P2_LEN - 1));
  assign booting  = (st == ST_BOOT);
  assign at_check = (st == ST_P1) && (cnt == CW'(P1_SHORT - 1));

endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
#(
  parameter int P1_LONG  = 44,
  parameter int P1_SHORT = 14,
  parameter int P2_LEN   = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmreq,
  input  logic       seq,
  input  logic       a2,
  input  logic       a3,
  input  logic       legacy,
  output logic       phase1,
  output logic       phase2,
  output logic [1:0] cyc_tag,
  output logic       cycle_done
);

  localparam int P1_SLOW = 2 * P1_SHORT + P2_LEN;
  localparam int MAX_A   = (P1_LONG > P1_SLOW) ? P1_LONG : P1_SLOW;
  localparam int MAX_L   = (MAX_A > P2_LEN) ? MAX_A : P2_LEN;
  localparam int CW      = $clog2(MAX_L + 1);

  req_t          req;
  cyc_tag_t      tag;
  cyc_tag_t      start_tag;
  cyc_tag_t      last_tag;
  logic [CW-1:0] start_len;
  logic          merge_now;
  logic          booting;
  logic          at_check;
  logic          cur_req_i;
  logic          last_was_i;
  logic          advance;

  assign req        = decode_req(nmreq, seq);
  assign last_tag   = booting ? TAG_S : tag;
  assign last_was_i = booting ? 1'b0 : cur_req_i;
  assign advance    = booting || cycle_done;

  mcyc_classify #(
    .CW(CW), .P1_LONG(P1_LONG), .P1_SHORT(P1_SHORT), .P1_SLOW(P1_SLOW)
  ) u_classify (
    .req       (req),
    .legacy    (legacy),
    .last_tag  (last_tag),
    .last_was_i(last_was_i),
    .start_tag (start_tag),
    .start_len (start_len)
  );

  mcyc_merge u_merge (
    .at_check (at_check),
    .cur_tag  (tag),
    .req      (req),
    .a2       (a2),
    .a3       (a3),
    .legacy   (legacy),
    .merge_now(merge_now)
  );

  mcyc_phase_gen #(
    .CW(CW), .P1_LONG(P1_LONG), .P1_SHORT(P1_SHORT), .P2_LEN(P2_LEN)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_tag(start_tag),
    .start_len(start_len),
    .merge_now(merge_now),
    .phase1   (phase1),
    .phase2   (phase2),
    .done     (cycle_done),
    .booting  (booting),
    .at_check (at_check),
    .tag      (tag)
  );

  // whether the running cycle came from an internal announcement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_req_i <= 1'b0;
    else if (advance)
      cur_req_i <= (req == REQ_I);
    else if (merge_now)
      cur_req_i <= 1'b0;
  end

  assign cyc_tag = tag;

endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nmreq,
  input logic       seq,
  input logic       a2,
  input logic       a3,
  input logic       legacy,
  input logic       phase1,
  input logic       phase2,
  input logic [1:0] cyc_tag,
  input logic       cycle_done
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!phase1 && !phase2 && !cycle_done);
    end
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase1 && phase2));

  // R2
  done_in_p2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> phase2);

  // R2
  next_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> phase1);

  // R2
  p2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase2 && !cycle_done) |=> phase2);

  // R6
  tag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase2 && !cycle_done) |=> $stable(cyc_tag));

  // R8
  fuse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase1 && $past(phase1) && cyc_tag == 2'b11 && $past(cyc_tag) != 2'b11)
      |-> ($past(cyc_tag) == 2'b10 && !$past(legacy && a2 && a3) && $past(!nmreq && seq)));

endmodule

bind mcyc_seq mcyc_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .nmreq     (nmreq),
  .seq       (seq),
  .a2        (a2),
  .a3        (a3),
  .legacy    (legacy),
  .phase1    (phase1),
  .phase2    (phase2),
  .cyc_tag   (cyc_tag),
  .cycle_done(cycle_done)
);

// File: tb/mcyc_seq_bench.sv
`timescale 1ns/1ps
module mcyc_seq_bench;

  localparam logic [3:0] E_N   = 4'b0000;  // {nmreq,seq,a2,a3}
  localparam logic [3:0] E_S   = 4'b0100;
  localparam logic [3:0] E_S10 = 4'b0110;
  localparam logic [3:0] E_S11 = 4'b0111;
  localparam logic [3:0] E_I   = 4'b1000;
  localparam logic [3:0] E_I1  = 4'b1100;
  localparam logic [1:0] T_N = 2'b00, T_S = 2'b01, T_I = 2'b10, T_M = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmreq, seq, a2, a3, legacy;
  logic phase1, phase2, cycle_done;
  logic [1:0] cyc_tag;

  int checks = 0;
  int fails  = 0;

  logic [3:0] scr [0:15];
  logic [1:0] etag [0:15];
  int         ep1 [0:15];
  int         n_in, n_cyc;

  always #2 clk = ~clk;

  mcyc_seq u_mcyc_seq (
    .clk(clk), .rst_n(rst_n), .nmreq(nmreq), .seq(seq), .a2(a2), .a3(a3),
    .legacy(legacy), .phase1(phase1), .phase2(phase2), .cyc_tag(cyc_tag),
    .cycle_done(cycle_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] e);
    {nmreq, seq, a2, a3} = e;
  endtask

  task automatic clear_script();
    for (int i = 0; i < 16; i++) begin
      scr[i] = E_N; etag[i] = T_N; ep1[i] = 0;
    end
    n_in = 0; n_cyc = 0;
  endtask

  task automatic add(input logic [3:0] e);
    scr[n_in] = e; n_in++;
  endtask

  task automatic expect_cyc(input logic [1:0] t, input int p1);
    etag[n_cyc] = t; ep1[n_cyc] = p1; n_cyc++;
  endtask

  task automatic do_reset(input logic mode, input bit chk);
    rst_n = 1'b0;
    legacy = mode;
    drive(scr[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (chk) begin
      // R1 outputs quiet in reset
      check(!phase1, "R1", "phase1 in reset", phase1, 0);
      check(!phase2, "R1", "phase2 in reset", phase2, 0);
      check(!cycle_done, "R1", "done in reset", cycle_done, 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic run(input string req);
    int idx = 0;
    bit overlap = 0;
    for (int c = 0; c < n_cyc; c++) begin
      int p1 = 0, p2 = 0, guard = 0;
      bit sent = 0;
      while (1) begin
        @(negedge clk);
        guard++;
        if (phase1 && phase2) overlap = 1;
        if (phase1) p1++;
        if (phase2) p2++;
        if (phase1 && !sent) begin
          drive(scr[idx + 1]);
          sent = 1;
        end
        if (cycle_done || guard > 200) break;
      end
      check(cyc_tag == etag[c], req, $sformatf("cycle %0d tag", c), cyc_tag, etag[c]);
      check(p1 == ep1[c], req, $sformatf("cycle %0d phase1 ticks", c), p1, ep1[c]);
      check(p2 == 14, "R2", $sformatf("cycle %0d phase2 ticks", c), p2, 14);
      idx += (etag[c] == T_M) ? 2 : 1;
      drive(scr[idx]);
    end
    check(!overlap, "R2", "phase overlap seen", overlap, 0);
  endtask

  // R3 R4 R5: plain decoding in corrected mode
  task automatic t_basic();
    clear_script();
    add(E_N); add(E_S); add(E_S); add(E_N); add(E_I1); add(E_N);
    expect_cyc(T_N, 44); expect_cyc(T_S, 14); expect_cyc(T_S, 14);
    expect_cyc(T_N, 44); expect_cyc(T_I, 14); expect_cyc(T_N, 44);
    do_reset(1'b0, 1'b1);
    run("R3/R4/R5");
  endtask

  // R6 R7: corrected mode fuses even with both address bits set
  task automatic t_fuse_fixed();
    clear_script();
    add(E_S); add(E_I); add(E_S11); add(E_N);
    expect_cyc(T_S, 14); expect_cyc(T_M, 44); expect_cyc(T_N, 44);
    do_reset(1'b0, 1'b0);
    run("R6/R7");
  endtask

  // R6: legacy fuses when only one address bit set
  task automatic t_fuse_legacy();
    clear_script();
    add(E_S); add(E_I); add(E_S10); add(E_N);
    expect_cyc(T_S, 14); expect_cyc(T_M, 44); expect_cyc(T_N, 44);
    do_reset(1'b1, 1'b0);
    run("R6");
  endtask

  // R8: legacy blocks fusing with both bits set
  task automatic t_block_legacy();
    clear_script();
    add(E_S); add(E_I); add(E_S11); add(E_N);
    expect_cyc(T_S, 14); expect_cyc(T_I, 14); expect_cyc(T_S, 14); expect_cyc(T_N, 44);
    do_reset(1'b1, 1'b0);
    run("R8");
  endtask

  // R9 R10: slow internal after N, fast after fused
  task automatic t_slow_legacy();
    clear_script();
    add(E_N); add(E_I); add(E_N); add(E_I); add(E_S); add(E_I); add(E_N);
    expect_cyc(T_N, 44); expect_cyc(T_I, 42); expect_cyc(T_N, 44);
    expect_cyc(T_M, 44); expect_cyc(T_I, 14); expect_cyc(T_N, 44);
    do_reset(1'b1, 1'b0);
    run("R9/R10");
  endtask

  // R7: corrected mode, no slow internal cycle
  task automatic t_slow_fixed();
    clear_script();
    add(E_N); add(E_I); add(E_N);
    expect_cyc(T_N, 44); expect_cyc(T_I, 14); expect_cyc(T_N, 44);
    do_reset(1'b0, 1'b0);
    run("R7");
  endtask

  // R11: legacy run of internal cycles turns later ones into N, no fuse
  task automatic t_chain_legacy();
    clear_script();
    add(E_S); add(E_I); add(E_I); add(E_I); add(E_S); add(E_N);
    expect_cyc(T_S, 14); expect_cyc(T_I, 14); expect_cyc(T_N, 44);
    expect_cyc(T_N, 44); expect_cyc(T_S, 14); expect_cyc(T_N, 44);
    do_reset(1'b1, 1'b0);
    run("R11");
  endtask

  // R7: corrected run of internal cycles, last one fuses
  task automatic t_chain_fixed();
    clear_script();
    add(E_S); add(E_I); add(E_I); add(E_I); add(E_S); add(E_N);
    expect_cyc(T_S, 14); expect_cyc(T_I, 14); expect_cyc(T_I, 14);
    expect_cyc(T_M, 44); expect_cyc(T_N, 44);
    do_reset(1'b0, 1'b0);
    run("R7");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    legacy = 1'b0;
    drive(E_N);
    t_basic();
    t_fuse_fixed();
    t_fuse_legacy();
    t_block_legacy();
    t_slow_legacy();
    t_slow_fixed();
    t_chain_legacy();
    t_chain_fixed();
    summary();
    $finish;
  end

endmodule